// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns two asynchronous port pins into interrupt requests. Each channel has a 3-bit select field that picks one of eight port pins. The channel only reads that pin and never drives it, so the pin keeps working for whatever else uses it. The chosen pin is synchronised and then corrected for polarity. Depending on the channel's mode, the block then latches the first active edge or passes the active level straight through as the channel's pending flag.

The interrupt controller reads the pending flags. When the CPU vectors to a channel's handler, it returns a one-cycle acknowledge for that channel. In edge mode the acknowledge clears the latched flag. In level mode the flag follows the pin, so a source that stays active keeps requesting. Configuration arrives as plain input ports. A change of configuration is picked up at the next clock edge and never counts as an edge by itself.

Top module: `ext_irq_cond`

## Requirements
- R1: While `rst` is high, and for the first three clock edges after it is released, every `pending` bit is 0. Reset also clears all edge history, so a pin held active through reset produces no edge.
- R2: Encoding per channel: `edgeMode`=1 selects edge sensitivity and 0 selects level sensitivity. `polarity`=1 makes a high pin active and 0 makes a low pin active. The four combinations behave independently.
- R3: In level mode, `pending[c]` equals the active state of the selected pin and is not latched. A pin change sampled at clock edge k appears on `pending` after edge k+2.
- R4: In level mode, `vecAck[c]` has no effect: if the pin is still active, `pending[c]` stays 1 and the request continues.
- R5: In edge mode, a change of the selected pin from inactive to active sets `pending[c]` after edge k+3 (k = the edge that first samples the change). A change from active to inactive, or a pin that stays active, does not set the flag. Once set, the flag holds until acknowledged.
- R6: In edge mode, a `vecAck[c]` pulse sampled at an edge clears `pending[c]` after that edge.
- R7: In edge mode, if a new active edge and `vecAck[c]` arrive in the same cycle, `pending[c]` stays 1.
- R8: `pinSel[c]` (3 bits, channel c at bits 3c+2..3c) with value n selects `portPins[n]`. Changes on any other pin have no effect on that channel.
- R9: The two channels are independent. Configuration, pin activity and acknowledges of one channel never change the other channel's `pending`.
- R10: A new value of `polarity`, `edgeMode` or `pinSel` takes effect at the next clock edge: a level-mode flag reflects it after that edge. A configuration change that makes the selected input look active never sets an edge-mode flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| portPins | input | 8 | Asynchronous port pin levels, observed only |
| pinSel | input | 6 | Per-channel pin select, 3 bits per channel |
| polarity | input | 2 | Per-channel active level, 1 = high |
| edgeMode | input | 2 | Per-channel sensitivity, 1 = edge, 0 = level |
| vecAck | input | 2 | Per-channel one-cycle vectoring acknowledge |
| pending | output | 2 | Per-channel interrupt pending flag |

## Verification
A stale or wrongly primed edge history in this block would show up as an extra request. That request appears on `pending` three to four edges after a configuration change or after reset, even though the pin did not move. A wrong polarity or select path would show in level mode within three edges, as a flag that does not match the pin. A lost or sticky latch would show one edge after an acknowledge, including the acknowledge that coincides with a new edge. The bench places each check at those edge counts, and drives stimulus aimed at each of these failure modes on both channels.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Per-channel strobes handed from the datapath to the control.
  typedef struct packed {
    logic rise;      // qualified inactive-to-active transition this cycle
    logic active;    // polarity-corrected level of the selected pin
    logic edgeMode;  // registered sensitivity, 1 = edge
    logic ready;     // synchroniser history is valid
  } chanStb_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PIN_COUNT-1:0]          portPins,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  pinSel,
  input  logic [NUM_CH-1:0]             polarity,
  input  logic [NUM_CH-1:0]             edgeMode,
  output chanStb_t [NUM_CH-1:0]         stb
);

  localparam int WARM  = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(WARM + 1);
  localparam int CFG_W = SEL_W + 2;

  logic [PIN_COUNT-1:0] pinSync;
  logic [CNT_W-1:0]     warmCnt;
  logic                 ready;

  ext_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (portPins),
    .dout (pinSync)
  );

  // Hold off edge detection until the synchroniser holds real samples.
  assign ready = (warmCnt == CNT_W'(WARM));

  always_ff @(posedge clk) begin
    if (rst)         warmCnt <= '0;
    else if (!ready) warmCnt <= warmCnt + CNT_W'(1);
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic             selBit;
      logic             actNext;
      logic [CFG_W-1:0] cfgNow;
      logic [CFG_W-1:0] cfgReg;
      logic             cfgDiff;
      logic             actCur;
      logic             actPrev;
      logic             hold;
      logic             modeReg;

      assign selBit  = pinSync[pinSel[c]];
      assign actNext = selBit ~^ polarity[c];
      assign cfgNow  = {pinSel[c], polarity[c], edgeMode[c]};
      assign cfgDiff = (cfgNow != cfgReg);

      always_ff @(posedge clk) begin
        if (rst) begin
          cfgReg  <= '0;
          actCur  <= 1'b0;
          actPrev <= 1'b0;
          hold    <= 1'b1;
          modeReg <= 1'b0;
        end else begin
          cfgReg  <= cfgNow;
          actCur  <= actNext;
          actPrev <= actCur;
          hold    <= !ready || cfgDiff;
          modeReg <= edgeMode[c];
        end
      end

      assign stb[c] = '{rise:     ready && !hold && actCur && !actPrev,
                        active:   actCur,
                        edgeMode: modeReg,
                        ready:    ready};
    end
  endgenerate

endmodule

// File: rtl/ext_irq_control.sv
module ext_irq_control
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  chanStb_t [NUM_CH-1:0] stb,
  input  logic [NUM_CH-1:0]     vecAck,
  output logic [NUM_CH-1:0]     pending
);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic latched;

      always_ff @(posedge clk) begin
        if (rst)                  latched <= 1'b0;
        else if (!stb[c].edgeMode) latched <= 1'b0;
        else                      latched <= (latched && !vecAck[c]) || stb[c].rise;
      end

      always_comb begin
        if (!stb[c].ready)        pending[c] = 1'b0;
        else if (stb[c].edgeMode) pending[c] = latched;
        else                      pending[c] = stb[c].active;
      end
    end
  endgenerate

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(PIN_COUNT)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PIN_COUNT-1:0]         portPins,
  input  logic [NUM_CH-1:0][SEL_W-1:0] pinSel,
  input  logic [NUM_CH-1:0]            polarity,
  input  logic [NUM_CH-1:0]            edgeMode,
  input  logic [NUM_CH-1:0]            vecAck,
  output logic [NUM_CH-1:0]            pending
);

  chanStb_t [NUM_CH-1:0] chanStb;

  ext_irq_datapath #(
    .NUM_CH(NUM_CH), .PIN_COUNT(PIN_COUNT),
    .SYNC_STAGES(SYNC_STAGES), .SEL_W(SEL_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .portPins (portPins),
    .pinSel   (pinSel),
    .polarity (polarity),
    .edgeMode (edgeMode),
    .stb      (chanStb)
  );

  ext_irq_control #(.NUM_CH(NUM_CH)) ctl_i (
    .clk     (clk),
    .rst     (rst),
    .stb     (chanStb),
    .vecAck  (vecAck),
    .pending (pending)
  );

endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_CH-1:0]     edgeMode,
  input logic [NUM_CH-1:0]     vecAck,
  input logic [NUM_CH-1:0]     pending,
  input chanStb_t [NUM_CH-1:0] stb
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pending == '0)); // R1

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stb[c].edgeMode && edgeMode[c] && pending[c] && !vecAck[c]) |=> pending[c]); // R5

      AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
        (stb[c].edgeMode && $past(stb[c].edgeMode) && $rose(pending[c])) |-> $past(stb[c].rise)); // R5

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stb[c].edgeMode && edgeMode[c] && vecAck[c] && !stb[c].rise) |=> !pending[c]); // R6

      AST_RISE_WINS_ACK: assert property (@(posedge clk) disable iff (rst)
        (stb[c].edgeMode && edgeMode[c] && stb[c].rise) |=> pending[c]); // R7

      AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!stb[c].edgeMode && $past(!stb[c].edgeMode) && $past(stb[c].ready)
         && $stable(stb[c].active)) |-> $stable(pending[c])); // R3
    end
  endgenerate

endmodule

bind ext_irq_cond ext_irq_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .edgeMode (edgeMode),
  .vecAck   (vecAck),
  .pending  (pending),
  .stb      (chanStb)
);

// File: tb/ext_irq_cond_tb_top.sv
`timescale 1ns/1ps
module ext_irq_cond_tb_top;

  logic            clk = 1'b0;
  logic            rst;
  logic [7:0]      portPins;
  logic [1:0][2:0] pinSel;
  logic [1:0]      polarity;
  logic [1:0]      edgeMode;
  logic [1:0]      vecAck;
  logic [1:0]      pending;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ext_irq_cond dut_i (
    .clk(clk), .rst(rst), .portPins(portPins), .pinSel(pinSel),
    .polarity(polarity), .edgeMode(edgeMode), .vecAck(vecAck), .pending(pending)
  );

  typedef struct packed {
    logic [7:0] pins;
    logic [2:0] sel;
    logic       pol;
    logic       mode;
    logic       ack;
    logic [3:0] waitN;
    logic       exp;
  } vec_t;

  localparam int NVEC = 19;
  // Channel 0 stimulus: pins, select, polarity, mode, ack, edges to wait, expected flag.
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0},  // R3 idle
    '{8'h01, 3'd0, 1'b1, 1'b0, 1'b0, 4'd3, 1'b1},  // R3 active high level
    '{8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0},  // R3 no latching
    '{8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1},  // R10 polarity next clock
    '{8'h01, 3'd0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},  // R2 active low level
    '{8'h01, 3'd3, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1},  // R8 select pin 3
    '{8'h09, 3'd3, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},  // R8 pin 3 high
    '{8'h08, 3'd3, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},  // R8 other pin ignored
    '{8'h08, 3'd3, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1},  // R10 polarity flip
    '{8'h08, 3'd3, 1'b1, 1'b0, 1'b1, 4'd3, 1'b1},  // R4 ack ignored in level
    '{8'h08, 3'd3, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0},  // R10 mode switch not an edge
    '{8'h00, 3'd3, 1'b1, 1'b1, 1'b0, 4'd4, 1'b0},  // R5 falling ignored
    '{8'h08, 3'd3, 1'b1, 1'b1, 1'b0, 4'd4, 1'b1},  // R5 rising sets
    '{8'h00, 3'd3, 1'b1, 1'b1, 1'b0, 4'd4, 1'b1},  // R5 holds
    '{8'h00, 3'd3, 1'b1, 1'b1, 1'b1, 4'd1, 1'b0},  // R6 ack clears
    '{8'h00, 3'd3, 1'b0, 1'b1, 1'b0, 4'd4, 1'b0},  // R10 polarity change not an edge
    '{8'h08, 3'd3, 1'b0, 1'b1, 1'b0, 4'd4, 1'b0},  // R2 leaving active low
    '{8'h00, 3'd3, 1'b0, 1'b1, 1'b0, 4'd4, 1'b1},  // R2 active low edge
    '{8'h00, 3'd3, 1'b0, 1'b1, 1'b1, 4'd1, 1'b0}   // R6 ack clears
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    portPins = 8'h00;
    pinSel[0] = 3'd0; polarity[0] = 1'b1; edgeMode[0] = 1'b0;
    pinSel[1] = 3'd7; polarity[1] = 1'b1; edgeMode[1] = 1'b0;
    vecAck = 2'b00;
    edges(5);
    check(pending[0], 1'b0, "R1 reset ch0");
    check(pending[1], 1'b0, "R1 reset ch1");
    rst = 1'b0;
    edges(6);

    for (int i = 0; i < NVEC; i++) begin
      portPins    = VECS[i].pins;
      pinSel[0]   = VECS[i].sel;
      polarity[0] = VECS[i].pol;
      edgeMode[0] = VECS[i].mode;
      vecAck[0]   = VECS[i].ack;
      @(posedge clk);
      #1 vecAck[0] = 1'b0;
      edges(int'(VECS[i].waitN) - 1);
      check(pending[0], VECS[i].exp, $sformatf("R%0s vector %0d", "x", i));
    end

    // R7: new edge coinciding with acknowledge keeps the flag.
    portPins = 8'h08; edges(4);
    portPins = 8'h00; edges(4);
    check(pending[0], 1'b1, "R5 active low edge sets");
    portPins = 8'h08; edges(4);
    check(pending[0], 1'b1, "R5 flag held after release");
    portPins = 8'h00;
    edges(3);
    vecAck[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vecAck[0] = 1'b0;
    check(pending[0], 1'b1, "R7 edge with ack");
    vecAck[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vecAck[0] = 1'b0;
    check(pending[0], 1'b0, "R6 ack alone clears");

    // R9: channel 1 edge, active low on pin 5, independent of channel 0.
    pinSel[1] = 3'd5; polarity[1] = 1'b0; edgeMode[1] = 1'b1;
    portPins = 8'h28;
    edges(4);
    check(pending[1], 1'b0, "R9 ch1 config no request");
    portPins = 8'h08;
    edges(4);
    check(pending[1], 1'b1, "R9 ch1 edge sets");
    check(pending[0], 1'b0, "R9 ch0 unaffected");
    vecAck[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vecAck[0] = 1'b0;
    check(pending[1], 1'b1, "R9 ch0 ack leaves ch1");
    vecAck[1] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vecAck[1] = 1'b0;
    check(pending[1], 1'b0, "R6 ch1 ack clears");

    // R1: reset with an active level input, then the warm-up window.
    edgeMode[0] = 1'b0; polarity[0] = 1'b1; pinSel[0] = 3'd0;
    portPins = 8'h01;
    rst = 1'b1;
    edges(3);
    check(pending[0], 1'b0, "R1 reset with active pin");
    rst = 1'b0;
    edges(2);
    check(pending[0], 1'b0, "R1 warm-up window");
    edges(2);
    check(pending[0], 1'b1, "R3 level after warm-up");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule